// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

The block keeps a small circular queue of in-flight operations between dispatch and retirement. Dispatch claims the slot at the tail and hands its index back, so the issuing logic can use that index as a rename tag for the result. Results come back in any order through a write-result port, which fills in the slot's value and marks it finished.

Retirement works strictly from the head, one slot per cycle at most, and only once the head slot is finished. What retirement does depends on the slot's kind. A register operation produces a register-file write. A store is released to memory only at this point. A branch retires silently when it was predicted correctly. When it was mispredicted, it raises a flush that discards every younger slot in one cycle and presents the correct target for fetch.

The depth must be a power of two, so that the slot pointers wrap on their own.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty (`empty`=1, `full`=0), nothing retires, and `disp_tag` is 0.
- R2: Each accepted dispatch (`disp_valid`=1 while `full`=0 and no flush) takes the slot shown on `disp_tag`. The tag advances by one per accepted dispatch, modulo the depth.
- R3: After depth dispatches without any retirement, `full` is 1. A dispatch attempted while full is ignored: `full` stays 1 and `disp_tag` does not move.
- R4: Nothing retires while the head slot has no result, even if younger slots already hold results. Nothing retires while the buffer is empty.
- R5: Kind code 0 (register) retires with `rf_we`=1, where `rf_addr` is the dispatched destination and `rf_data` is the written result.
- R6: Kind code 1 (store) retires with `st_release`=1, where `st_addr` is the dispatched destination and `st_data` is the written result. `rf_we` stays 0 for it.
- R7: Kind code 2 (branch) with its mispredict bit clear retires with `retire`=1, while `rf_we`, `st_release` and `flush` all stay 0.
- R8: A branch written back with `res_mispred`=1 raises `flush` when it reaches retirement, with `redirect` equal to its result value. On the next cycle the buffer is empty, and the next dispatch tag is the branch's tag plus one. Younger slots never retire.
- R9: At most one slot retires per cycle, and slots retire in dispatch order.
- R10: A result written to a slot that holds no operation is ignored, including when that slot is dispatched later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | Operation kind: 0 register, 1 store, 2 branch |
| disp_dest | input | REG_W | Destination register or store-queue index |
| disp_tag | output | TAG_W | Slot given to the current dispatch |
| res_valid | input | 1 | Result write strobe |
| res_tag | input | TAG_W | Slot that the result belongs to |
| res_value | input | DATA_W | Result value, or branch target |
| res_mispred | input | 1 | Branch outcome differs from the prediction |
| retire | output | 1 | Head slot retires this cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | REG_W | Register-file write address |
| rf_data | output | DATA_W | Register-file write data |
| st_release | output | 1 | Store released to memory |
| st_addr | output | REG_W | Store-queue index of the released store |
| st_data | output | DATA_W | Value of the released store |
| flush | output | 1 | Mispredicted branch retires; younger slots are discarded |
| redirect | output | DATA_W | Correct fetch target during flush |
| full | output | 1 | No free slot |
| empty | output | 1 | No slot in use |

## Verification
On every cycle, the assertions check that:
- the three retirement actions never overlap;
- an empty buffer never retires;
- a full buffer without retirement stays full;
- the tag steps once per accepted dispatch;
- a flush always leaves the buffer empty.

Only the bench's scenarios can show that retirement follows dispatch order and carries the right destination and value for each kind. The same holds for results that arrive in reverse order, a result aimed at an unused slot, and the tag position after a flush.

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [1:0]        disp_kind,
  input  logic [REG_W-1:0]  disp_dest,
  output logic [$clog2(DEPTH)-1:0] disp_tag,
  input  logic              res_valid,
  input  logic [$clog2(DEPTH)-1:0] res_tag,
  input  logic [DATA_W-1:0] res_value,
  input  logic              res_mispred,
  output logic              retire,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              st_release,
  output logic [REG_W-1:0]  st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic              flush,
  output logic [DATA_W-1:0] redirect,
  output logic              full,
  output logic              empty
);
  localparam int TAG_W = $clog2(DEPTH);
  localparam int CNT_W = TAG_W + 1;
  localparam logic [1:0] K_REG = 2'd0;
  localparam logic [1:0] K_ST  = 2'd1;
  localparam logic [1:0] K_BR  = 2'd2;

  logic [TAG_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;
  logic [DEPTH-1:0]  used_q, done_q, miss_q;
  logic [1:0]        kind_q [DEPTH];
  logic [REG_W-1:0]  dest_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];

  logic take;
  logic [1:0] hkind;

  assign full     = count_q == CNT_W'(DEPTH);
  assign empty    = count_q == '0;
  assign disp_tag = tail_q;
  assign hkind    = kind_q[head_q];

  assign retire     = used_q[head_q] && done_q[head_q];
  assign rf_we      = retire && hkind == K_REG;
  assign st_release = retire && hkind == K_ST;
  assign flush      = retire && hkind == K_BR && miss_q[head_q];
  assign rf_addr    = dest_q[head_q];
  assign st_addr    = dest_q[head_q];
  assign rf_data    = val_q[head_q];
  assign st_data    = val_q[head_q];
  assign redirect   = val_q[head_q];

  assign take = disp_valid && !full && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      used_q  <= '0;
      done_q  <= '0;
      miss_q  <= '0;
    end else if (flush) begin
      used_q  <= '0;
      head_q  <= head_q + 1'b1;
      tail_q  <= head_q + 1'b1;
      count_q <= '0;
    end else begin
      if (res_valid && used_q[res_tag]) begin
        done_q[res_tag] <= 1'b1;
        miss_q[res_tag] <= res_mispred;
        val_q[res_tag]  <= res_value;
      end
      if (take) begin
        used_q[tail_q] <= 1'b1;
        done_q[tail_q] <= 1'b0;
        miss_q[tail_q] <= 1'b0;
        kind_q[tail_q] <= disp_kind;
        dest_q[tail_q] <= disp_dest;
        tail_q         <= tail_q + 1'b1;
      end
      if (retire) begin
        used_q[head_q] <= 1'b0;
        head_q         <= head_q + 1'b1;
      end
      count_q <= count_q + CNT_W'(take) - CNT_W'(retire);
    end
  end
endmodule

module rob_core_chk #(
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic [TAG_W-1:0] disp_tag,
  input logic             retire,
  input logic             rf_we,
  input logic             st_release,
  input logic             flush,
  input logic             full,
  input logic             empty
);
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, st_release, flush})); // R9
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !retire); // R4
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !retire) |=> full); // R3
  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !full && !flush) |=> disp_tag == $past(disp_tag) + TAG_W'(1)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !retire)); // R8
endmodule

bind rob_core rob_core_chk #(.TAG_W($clog2(DEPTH))) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tag(disp_tag),
  .retire(retire), .rf_we(rf_we), .st_release(st_release), .flush(flush),
  .full(full), .empty(empty)
);

// File: tb/rob_core_bench.sv
module rob_core_bench;
  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, res_valid = 0, res_mispred = 0;
  logic [1:0] disp_kind = 0;
  logic [4:0] disp_dest = 0;
  logic [2:0] res_tag = 0;
  logic [31:0] res_value = 0;
  logic [2:0] disp_tag;
  logic retire, rf_we, st_release, flush, full, empty;
  logic [4:0] rf_addr, st_addr;
  logic [31:0] rf_data, st_data, redirect;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rob_core u_rob_core (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic dsp(input logic [1:0] k, input logic [4:0] d);
    disp_valid = 1; disp_kind = k; disp_dest = d;
    step();
    disp_valid = 0;
  endtask

  task automatic res(input logic [2:0] t, input logic [31:0] v, input bit m);
    res_valid = 1; res_tag = t; res_value = v; res_mispred = m;
    step();
    res_valid = 0; res_mispred = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    chk(empty && !full, "R1 flags", {empty, full}, 2'b10);
    chk(!retire, "R1 retire", retire, 0);
    chk(disp_tag == 0, "R1 tag", disp_tag, 0);

    // fill with register ops
    for (int i = 0; i < 8; i++) begin
      chk(disp_tag == 3'(i), "R2 tag", disp_tag, i);
      dsp(2'd0, 5'(i + 3));
    end
    chk(full, "R3 full", full, 1);
    dsp(2'd0, 5'd30);
    chk(full && disp_tag == 0, "R3 ignored", {full, disp_tag}, 4'b1000);

    // results in reverse order, head last
    for (int i = 7; i >= 1; i--) begin
      res(3'(i), 100 + i * 7, 0);
      chk(!retire, "R4 head pending", retire, 0);
    end
    res(3'd0, 100, 0);
    for (int i = 0; i < 8; i++) begin
      chk(rf_we && !st_release && !flush, "R9 single action", {rf_we, st_release, flush}, 3'b100);
      chk(rf_addr == 5'(i + 3), "R5 addr", rf_addr, i + 3);
      chk(rf_data == 32'(100 + i * 7), "R5 data", rf_data, 100 + i * 7);
      step();
    end
    chk(empty && !retire, "R9 drained", {empty, retire}, 2'b10);

    // stray result, then store and register
    res(3'd0, 32'h77, 0);
    dsp(2'd1, 5'd9);
    chk(!retire, "R10 stray result", retire, 0);
    dsp(2'd0, 5'd4);
    res(3'd1, 32'd55, 0);
    chk(!retire, "R4 younger done", retire, 0);
    res(3'd0, 32'hABCD, 0);
    chk(st_release && !rf_we, "R6 release", {st_release, rf_we}, 2'b10);
    chk(st_addr == 9 && st_data == 32'hABCD, "R6 payload", st_data, 32'hABCD);
    step();
    chk(rf_we && rf_addr == 4 && rf_data == 55, "R5 after store", rf_data, 55);
    step();
    chk(empty, "R9 empty", empty, 1);

    // correctly predicted branch
    dsp(2'd2, 5'd0);
    res(3'd2, 32'h40, 0);
    chk(retire && !rf_we && !st_release && !flush, "R7 quiet retire",
        {retire, rf_we, st_release, flush}, 4'b1000);
    step();
    chk(empty, "R7 empty", empty, 1);

    // mispredicted branch with younger work
    dsp(2'd0, 5'd1);
    dsp(2'd2, 5'd0);
    dsp(2'd0, 5'd2);
    dsp(2'd1, 5'd3);
    res(3'd5, 32'd21, 0);
    res(3'd6, 32'd22, 0);
    res(3'd4, 32'h200, 1);
    res(3'd3, 32'd11, 0);
    chk(rf_we && rf_addr == 1 && rf_data == 11, "R9 order", rf_data, 11);
    step();
    chk(flush && redirect == 32'h200, "R8 flush", redirect, 32'h200);
    step();
    chk(empty && !retire, "R8 emptied", {empty, retire}, 2'b10);
    chk(disp_tag == 5, "R8 tag", disp_tag, 5);
    dsp(2'd0, 5'd17);
    res(3'd5, 32'd99, 0);
    chk(rf_we && rf_addr == 17 && rf_data == 99, "R8 fresh slot", rf_data, 99);
    step();
    chk(empty, "R8 final empty", empty, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule